// File: doc/BRIEF.md
# Three-Valued Counting Gate Evaluator

This block evaluates a single AND, OR, NAND or NOR gate in three-valued logic (0, 1, unknown). It does not hold the individual input values. It keeps two counters: the number of inputs currently at the gate's controlling value, and the number of inputs currently unknown. The counters are updated in place from input-change events. Each event carries the old and the new value of one input. The gate result is then derived from the two counts alone, so the cost of an evaluation does not depend on the fan-in.

An event-driven logic engine around the block takes care of the netlist and of scheduling. It presents one input transition per cycle. It can also load both counters in one cycle from a full initial input vector. It reads back the registered result and a one-cycle pulse that marks a change of that result. The pulse tells the engine whether the fanout has to be scheduled.

Counts are classified against the gate type present in the cycle of the event or load. A change of gate type therefore needs a fresh load. Until then the stored controlling count refers to the old type. After reset, every input is taken to be unknown.

Top module: `tgc_gate_eval`

## Requirements
- R1: Values are 2-bit codes: 00 is 0, 01 is 1, 10 is unknown. On any input the code 11 is treated as unknown. `out_val` only ever shows 00, 01 or 10.
- R2: `gate_type` bit 0 is the controlling value c and bit 1 is the inversion flag i: 00 selects AND, 01 OR, 10 NAND, 11 NOR.
- R3: When at least one input is at the controlling value, the result is c XOR i.
- R4: When no input is at the controlling value and at least one input is unknown, the result is unknown (10).
- R5: When no input is at the controlling value and none is unknown, the result is (NOT c) XOR i.
- R6: When `ev_valid` is high, the count for the class of `ev_old` goes down by one and the count for the class of `ev_new` goes up by one. `out_val` shows the new result after the same clock edge.
- R7: An event whose old and new codes fall in the same class (equal codes, or 10 and 11) changes nothing.
- R8: When `init_en` is high, both counts are loaded from `init_vec`, where input k sits in bits 2k+1:2k. A load takes precedence over an event in the same cycle.
- R9: `out_changed` is high for exactly the one cycle in which `out_val` holds a value different from the one it held in the cycle before.
- R10: Synchronous active-high `rst` takes precedence over loads and events. It sets every input to unknown (unknown count N, controlling count 0), sets `out_val` to 10 and clears `out_changed`.
- R11: The counts cover the full range 0 to N. With all N inputs at the controlling value, the result leaves c XOR i only when the last of them leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_type | input | 2 | {inversion, controlling value} |
| init_en | input | 1 | Load both counts from init_vec |
| init_vec | input | 2*N_IN | Initial value of every input, 2 bits each |
| ev_valid | input | 1 | One input transition is presented |
| ev_old | input | 2 | Value of that input before the transition |
| ev_new | input | 2 | Value of that input after the transition |
| out_val | output | 2 | Registered three-valued gate result |
| out_changed | output | 1 | One-cycle pulse when out_val changed |

## Verification
The bench drives an input with the controlling value and an unknown input at the same time. A design that let the unknown win would show 10 where 0 or 1 is due. Events that stay in the same class, including the switch from 10 to 11, must leave the result and the pulse alone. A design that compared raw codes would corrupt the counts. The bench walks all sixteen inputs out of the controlling value, and all sixteen out of the unknown state after reset. An undersized counter or a wrong reset count would flip the output too early or too late. The bench also issues a load together with an event, and a reset together with a load. A wrong priority order would leave counts that disagree with the expected result.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

  typedef logic [1:0] tval_t;

  localparam tval_t TV_ZERO = 2'b00;
  localparam tval_t TV_ONE  = 2'b01;
  localparam tval_t TV_UNK  = 2'b10;

  // code 11 is folded into the unknown class
  function automatic logic tv_is_unk(input tval_t v);
    return v[1];
  endfunction

  function automatic logic tv_is_ctrl(input tval_t v, input logic ctrl_val);
    return (!v[1]) && (v[0] == ctrl_val);
  endfunction

endpackage

// File: rtl/tgc_init_census.sv
module tgc_init_census
  import tgc_pkg::*;
#(
  parameter int N_IN  = 16,
  parameter int CNT_W = $clog2(N_IN + 1)
) (
  input  logic [2*N_IN-1:0] vec,
  input  logic              ctrl_val,
  output logic [CNT_W-1:0]  ctrl_cnt,
  output logic [CNT_W-1:0]  unk_cnt
);

  logic [N_IN-1:0] ctrl_flag;
  logic [N_IN-1:0] unk_flag;

  for (genvar k = 0; k < N_IN; k++) begin : g_input
    assign ctrl_flag[k] = tv_is_ctrl(vec[2*k +: 2], ctrl_val);
    assign unk_flag[k]  = tv_is_unk(vec[2*k +: 2]);
  end

  always_comb begin
    ctrl_cnt = '0;
    unk_cnt  = '0;
    for (int k = 0; k < N_IN; k++) begin
      ctrl_cnt = ctrl_cnt + CNT_W'(ctrl_flag[k]);
      unk_cnt  = unk_cnt + CNT_W'(unk_flag[k]);
    end
  end

endmodule

// File: rtl/tgc_counters.sv
module tgc_counters
  import tgc_pkg::*;
#(
  parameter int N_IN  = 16,
  parameter int CNT_W = $clog2(N_IN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_val,
  input  logic              load_en,
  input  logic [CNT_W-1:0]  load_ctrl,
  input  logic [CNT_W-1:0]  load_unk,
  input  logic              ev_valid,
  input  tval_t             ev_old,
  input  tval_t             ev_new,
  output logic [CNT_W-1:0]  ctrl_q,
  output logic [CNT_W-1:0]  unk_q,
  output logic [CNT_W-1:0]  ctrl_d,
  output logic [CNT_W-1:0]  unk_d
);

  localparam logic [CNT_W-1:0] ALL_IN = CNT_W'(N_IN);

  logic old_ctrl, new_ctrl, old_unk, new_unk;

  assign old_ctrl = tv_is_ctrl(ev_old, ctrl_val);
  assign new_ctrl = tv_is_ctrl(ev_new, ctrl_val);
  assign old_unk  = tv_is_unk(ev_old);
  assign new_unk  = tv_is_unk(ev_new);

  // next values as loaded when rst is low
  always_comb begin
    ctrl_d = ctrl_q;
    unk_d  = unk_q;
    if (load_en) begin
      ctrl_d = load_ctrl;
      unk_d  = load_unk;
    end else if (ev_valid) begin
      ctrl_d = ctrl_q + CNT_W'(new_ctrl) - CNT_W'(old_ctrl);
      unk_d  = unk_q + CNT_W'(new_unk) - CNT_W'(old_unk);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      unk_q  <= ALL_IN;
    end else begin
      ctrl_q <= ctrl_d;
      unk_q  <= unk_d;
    end
  end

  AST_NO_CTRL_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !load_en && old_ctrl && !new_ctrl) |-> (ctrl_q != '0)) // R6
    else $error("controlling count underflow");

  AST_NO_UNK_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !load_en && old_unk && !new_unk) |-> (unk_q != '0)) // R6
    else $error("unknown count underflow");

  AST_SAME_CLASS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !load_en && (old_ctrl == new_ctrl) && (old_unk == new_unk))
      |=> ($stable(ctrl_q) && $stable(unk_q))) // R7
    else $error("same-class event moved a count");

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (({1'b0, ctrl_q} + {1'b0, unk_q}) <= {1'b0, ALL_IN})) // R11
    else $error("counts exceed input total");

endmodule

// File: rtl/tgc_resolve.sv
module tgc_resolve
  import tgc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [1:0]       gate_type,
  input  logic [CNT_W-1:0] ctrl_cnt,
  input  logic [CNT_W-1:0] unk_cnt,
  output tval_t            result
);

  logic ctrl_val, inv;

  assign ctrl_val = gate_type[0];
  assign inv      = gate_type[1];

  always_comb begin
    if (ctrl_cnt != '0)
      result = {1'b0, ctrl_val ^ inv};
    else if (unk_cnt != '0)
      result = TV_UNK;
    else
      result = {1'b0, ~ctrl_val ^ inv};
  end

endmodule

// File: rtl/tgc_gate_eval.sv
module tgc_gate_eval
  import tgc_pkg::*;
#(
  parameter int N_IN  = 16,
  localparam int CNT_W = $clog2(N_IN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        gate_type,
  input  logic              init_en,
  input  logic [2*N_IN-1:0] init_vec,
  input  logic              ev_valid,
  input  logic [1:0]        ev_old,
  input  logic [1:0]        ev_new,
  output logic [1:0]        out_val,
  output logic              out_changed
);

  logic [CNT_W-1:0] load_ctrl, load_unk;
  logic [CNT_W-1:0] ctrl_q, unk_q, ctrl_d, unk_d;
  tval_t            res_next;

  tgc_init_census #(.N_IN(N_IN), .CNT_W(CNT_W)) u_census (
    .vec      (init_vec),
    .ctrl_val (gate_type[0]),
    .ctrl_cnt (load_ctrl),
    .unk_cnt  (load_unk)
  );

  tgc_counters #(.N_IN(N_IN), .CNT_W(CNT_W)) u_counters (
    .clk       (clk),
    .rst       (rst),
    .ctrl_val  (gate_type[0]),
    .load_en   (init_en),
    .load_ctrl (load_ctrl),
    .load_unk  (load_unk),
    .ev_valid  (ev_valid),
    .ev_old    (ev_old),
    .ev_new    (ev_new),
    .ctrl_q    (ctrl_q),
    .unk_q     (unk_q),
    .ctrl_d    (ctrl_d),
    .unk_d     (unk_d)
  );

  tgc_resolve #(.CNT_W(CNT_W)) u_resolve (
    .gate_type (gate_type),
    .ctrl_cnt  (ctrl_d),
    .unk_cnt   (unk_d),
    .result    (res_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_val     <= TV_UNK;
      out_changed <= 1'b0;
    end else begin
      out_val     <= res_next;
      out_changed <= (res_next != out_val);
    end
  end

  AST_OUT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_val != 2'b11)) // R1
    else $error("illegal output code");

  AST_CTRL_DOMINATES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ctrl_q != '0) ->
      (out_val == {1'b0, $past(gate_type[0] ^ gate_type[1])}))) // R3
    else $error("controlling input did not decide the result");

  AST_UNKNOWN_RESULT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((ctrl_q == '0) && (unk_q != '0)) -> (out_val == TV_UNK))) // R4
    else $error("unknown input did not give unknown result");

  AST_CHANGE_PULSE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_changed == (out_val != $past(out_val)))) // R9
    else $error("change pulse disagrees with output history");

endmodule

// File: tb/tgc_gate_eval_tb.sv
`timescale 1ns/1ps
module tgc_gate_eval_tb;

  localparam int N_IN = 16;
  localparam int ROWS = 19;

  // {gate[1:0], is_init, vec[31:0], old[1:0], new[1:0], exp_out[1:0], exp_chg}
  localparam logic [41:0] TBL [ROWS] = '{
    {2'd0, 1'b1, 32'h5555_5555, 2'b00, 2'b00, 2'b01, 1'b1},
    {2'd0, 1'b0, 32'h0,         2'b01, 2'b00, 2'b00, 1'b1},
    {2'd0, 1'b0, 32'h0,         2'b00, 2'b10, 2'b10, 1'b1},
    {2'd0, 1'b0, 32'h0,         2'b01, 2'b00, 2'b00, 1'b1},
    {2'd0, 1'b0, 32'h0,         2'b10, 2'b01, 2'b00, 1'b0},
    {2'd0, 1'b0, 32'h0,         2'b00, 2'b01, 2'b01, 1'b1},
    {2'd0, 1'b0, 32'h0,         2'b01, 2'b01, 2'b01, 1'b0},
    {2'd0, 1'b0, 32'h0,         2'b01, 2'b11, 2'b10, 1'b1},
    {2'd0, 1'b0, 32'h0,         2'b11, 2'b10, 2'b10, 1'b0},
    {2'd0, 1'b0, 32'h0,         2'b10, 2'b01, 2'b01, 1'b1},
    {2'd2, 1'b1, 32'h5555_5555, 2'b00, 2'b00, 2'b00, 1'b1},
    {2'd2, 1'b0, 32'h0,         2'b01, 2'b00, 2'b01, 1'b1},
    {2'd1, 1'b1, 32'h0,         2'b00, 2'b00, 2'b00, 1'b1},
    {2'd1, 1'b0, 32'h0,         2'b00, 2'b01, 2'b01, 1'b1},
    {2'd1, 1'b0, 32'h0,         2'b00, 2'b10, 2'b01, 1'b0},
    {2'd1, 1'b0, 32'h0,         2'b01, 2'b00, 2'b10, 1'b1},
    {2'd3, 1'b1, 32'h0000_0002, 2'b00, 2'b00, 2'b10, 1'b0},
    {2'd3, 1'b0, 32'h0,         2'b00, 2'b01, 2'b00, 1'b1},
    {2'd3, 1'b1, 32'hAAAA_AAAA, 2'b00, 2'b00, 2'b10, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic [1:0]        gate_type;
  logic              init_en;
  logic [2*N_IN-1:0] init_vec;
  logic              ev_valid;
  logic [1:0]        ev_old, ev_new;
  logic [1:0]        out_val;
  logic              out_changed;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  tgc_gate_eval #(.N_IN(N_IN)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .gate_type   (gate_type),
    .init_en     (init_en),
    .init_vec    (init_vec),
    .ev_valid    (ev_valid),
    .ev_old      (ev_old),
    .ev_new      (ev_new),
    .out_val     (out_val),
    .out_changed (out_changed)
  );

  task automatic check(input string what, input logic [1:0] exp_v, input logic exp_c);
    n_checks++;
    if (out_val !== exp_v || out_changed !== exp_c) begin
      n_fail++;
      $display("FAIL %s: out=%b chg=%b expected out=%b chg=%b",
               what, out_val, out_changed, exp_v, exp_c);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic ld, input logic [2*N_IN-1:0] vec,
                      input logic ev, input logic [1:0] o, input logic [1:0] n);
    init_en  = ld;
    init_vec = vec;
    ev_valid = ev;
    ev_old   = o;
    ev_new   = n;
    @(negedge clk);
    init_en  = 1'b0;
    ev_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; gate_type = 2'd0; init_en = 1'b0; init_vec = '0;
    ev_valid = 1'b0; ev_old = 2'b00; ev_new = 2'b00;
    repeat (3) @(negedge clk);
    check("R10 reset state", 2'b10, 1'b0);
    rst = 1'b0;

    // table walk: gate types, dominance, unknown, same-class events, loads
    for (int r = 0; r < ROWS; r++) begin
      logic [41:0] e;
      e = TBL[r];
      gate_type = e[41:40];
      step(e[39], e[38:7], !e[39], e[6:5], e[4:3]);
      check($sformatf("table row %0d [R1 R2 R3 R4 R5 R6 R7 R8 R9]", r), e[2:1], e[0]);
    end

    // R8: load wins over a same-cycle event
    gate_type = 2'd0;
    step(1'b1, 32'h5555_5555, 1'b1, 2'b01, 2'b00);
    check("R8 load over event", 2'b01, 1'b1);
    step(1'b0, '0, 1'b0, 2'b00, 2'b00);
    check("R9 pulse lasts one cycle", 2'b01, 1'b0);
    step(1'b0, '0, 1'b1, 2'b01, 2'b00);
    check("R8 counts after load", 2'b00, 1'b1);

    // R11: all sixteen inputs controlling, release one at a time
    step(1'b1, 32'h0, 1'b0, 2'b00, 2'b00);
    check("R11 full controlling load", 2'b00, 1'b0);
    for (int k = 0; k < N_IN - 1; k++) step(1'b0, '0, 1'b1, 2'b00, 2'b01);
    check("R11 one controlling input left", 2'b00, 1'b0);
    step(1'b0, '0, 1'b1, 2'b00, 2'b01);
    check("R11 last controlling input gone", 2'b01, 1'b1);

    // R10: reset beats load and event, all inputs become unknown
    rst = 1'b1;
    step(1'b1, 32'h5555_5555, 1'b1, 2'b01, 2'b00);
    rst = 1'b0;
    check("R10 reset over load", 2'b10, 1'b0);
    for (int k = 0; k < N_IN - 1; k++) step(1'b0, '0, 1'b1, 2'b10, 2'b01);
    check("R10 one unknown input left", 2'b10, 1'b0);
    step(1'b0, '0, 1'b1, 2'b10, 2'b01);
    check("R10 last unknown resolved", 2'b01, 1'b1);

    // R2 and R5: zero counts under different gate types
    gate_type = 2'd3;
    step(1'b0, '0, 1'b0, 2'b00, 2'b00);
    check("R2 NOR with no controlling input", 2'b01, 1'b0);
    gate_type = 2'd1;
    step(1'b0, '0, 1'b0, 2'b00, 2'b00);
    check("R5 OR with no controlling input", 2'b00, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule